// File: doc/BRIEF.md
# Event-driven Manchester serial transmitter

This block accepts one 32-bit address event at a time from a parallel valid/ready port and sends it out on a single serial data line. Each event goes out as a burst of 34 bits: a two-bit alignment preamble comes first, then the event word. Every bit is Manchester coded, so a receiver can recover the bit clock from the data alone. The block runs on a local clock at twice the bit rate, and one clock cycle carries one half-bit.

A serial request line is raised with the first half-bit of a burst. The receiver answers on a serial acknowledge line, and the two lines follow a four-phase protocol. The transmitter drops its request only after the burst is complete and it has seen the acknowledge. It takes no new parallel event until the acknowledge has dropped again. Between events the serial line stays low and carries no idle or comma symbols. A new event starts on the next clock with no training sequence.

Top module: `manch_event_tx`

## Requirements
- R1: After reset, and whenever no event is in flight, ser_out is 0, sreq is 0 and in_ready is 1.
- R2: An event is accepted on a rising clock edge where in_valid and in_ready are both 1. The first half-bit of its burst appears on ser_out in the clock cycle right after that edge, and sreq is 1 in that same cycle.
- R3: A burst carries 34 bits. The preamble comes first as 1 then 0, and then the 32 event bits follow with the most significant bit first.
- R4: Manchester coding: a 1 is sent as high in the first half and low in the second half, and a 0 is sent as low then high. Each half lasts exactly one clock cycle.
- R5: A burst lasts exactly 68 clock cycles. After it, ser_out is 0 until the next burst.
- R6: sreq stays 1 until the burst is complete. It then falls in the cycle after sack is first sampled high once the burst has ended, including when sack went high early, during the burst.
- R7: From acceptance until sack has been sampled low after sreq fell, in_ready is 0. in_valid and in_data have no effect on the burst in flight during that time.
- R8: in_ready returns to 1 in the cycle after sack is sampled low. An event that is already waiting is accepted on the next edge and starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (twice the bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parallel event is offered |
| in_data | input | 32 | Parallel event word |
| in_ready | output | 1 | Transmitter can accept an event |
| ser_out | output | 1 | Manchester-coded serial data |
| sreq | output | 1 | Serial request toward the receiver |
| sack | input | 1 | Serial acknowledge from the receiver |

## Verification
Event words are walking ones and walking zeros over all 32 positions, plus all-zero, all-one, alternating and pseudo-random words. Every half-bit of every burst is compared against a frame the bench builds itself, so any error in bit order, preamble value, coding polarity or burst length shows up at a specific position. The receiver's acknowledge is given at varying delays and also early, in the middle of a burst, which separates correct request holding from dropping the request too soon. Conflicting parallel words are offered while the block is busy, and one event is queued during release, which shows whether the block ignores input while busy and whether a waiting event starts at once.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RELEASE = 2'd3
  } link_state_t;

  // level on the line for one half of a coded bit
  function automatic logic manch_level(input logic data_bit, input logic second_half);
    return data_bit ^ second_half;
  endfunction

  // number of clock ticks in one burst
  function automatic int unsigned burst_ticks(input int unsigned frame_bits);
    return 2 * frame_bits;
  endfunction

endpackage

// File: rtl/mtx_shifter.sv
module mtx_shifter #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRE_W    = 2,
  parameter logic [PRE_W-1:0] PREAMBLE = 2'b10,
  localparam int unsigned FRAME_W = DATA_W + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              advance,
  output logic              cur_bit
);

  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_q <= '0;
    else if (load)
      frame_q <= {PREAMBLE, data};
    else if (advance)
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
  end

  assign cur_bit = frame_q[FRAME_W-1];

endmodule

// File: rtl/mtx_timer.sv
module mtx_timer #(
  parameter int unsigned FRAME_W = 34,
  localparam int unsigned IDX_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic second_half,
  output logic last_tick
);

  logic             half_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      half_q <= 1'b0;
      idx_q  <= '0;
    end else if (active) begin
      half_q <= ~half_q;
      if (half_q) idx_q <= idx_q + 1'b1;
    end
  end

  assign second_half = half_q;
  assign last_tick   = active && half_q && (idx_q == IDX_W'(FRAME_W - 1));

  a_r4_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && !last_tick) |=> (second_half != $past(second_half)));

endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        sack,
  input  logic        last_tick,
  output link_state_t state,
  output logic        load,
  output logic        sending,
  output logic        in_ready,
  output logic        sreq
);

  link_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (in_valid)  state_d = ST_SEND;
      ST_SEND:    if (last_tick) state_d = ST_HOLD;
      ST_HOLD:    if (sack)      state_d = ST_RELEASE;
      ST_RELEASE: if (!sack)     state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_ready && in_valid;
  assign sending  = (state_q == ST_SEND);
  assign sreq     = (state_q == ST_SEND) || (state_q == ST_HOLD);

  a_r2_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sending && sreq && !in_ready));
  a_r6_sreq_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sreq) |-> $past(sack));
  a_r8_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> !$past(sack));

endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sending,
  input  logic cur_bit,
  input  logic second_half,
  output logic ser_out
);

  assign ser_out = sending ? manch_level(cur_bit, second_half) : 1'b0;

  a_r4_mid_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && second_half && $past(sending)) |-> (ser_out != $past(ser_out)));

endmodule

// File: rtl/manch_event_tx.sv
module manch_event_tx
  import mtx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 2,
  parameter logic [PRE_W-1:0] PREAMBLE = 2'b10,
  localparam int unsigned FRAME_W = DATA_W + PRE_W,
  localparam int unsigned TICKS   = 2 * FRAME_W,
  localparam int unsigned CNT_W   = $clog2(TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              ser_out,
  output logic              sreq,
  input  logic              sack
);

  link_state_t state;
  logic load, sending, cur_bit, second_half, last_tick;

  mtx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sack(sack),
    .last_tick(last_tick), .state(state), .load(load), .sending(sending),
    .in_ready(in_ready), .sreq(sreq)
  );

  mtx_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(load), .active(sending),
    .second_half(second_half), .last_tick(last_tick)
  );

  mtx_shifter #(.DATA_W(DATA_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .data(in_data),
    .advance(sending && second_half), .cur_bit(cur_bit)
  );

  mtx_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .sending(sending), .cur_bit(cur_bit),
    .second_half(second_half), .ser_out(ser_out)
  );

  // burst length watch for the assertion
  logic [CNT_W-1:0] send_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       send_len_q <= '0;
    else if (load)    send_len_q <= '0;
    else if (sending) send_len_q <= send_len_q + 1'b1;
  end

  a_r5_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sending) |-> (send_len_q == CNT_W'(burst_ticks(FRAME_W))));
  a_r1_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_out && !sreq));

endmodule

// File: tb/test_manch_event_tx.sv
`timescale 1ns/1ps
module test_manch_event_tx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, ser_out, sreq;
  logic sack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  manch_event_tx i_manch_event_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ser_out(ser_out), .sreq(sreq), .sack(sack)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected line level for half-tick j of a burst carrying d
  function automatic logic exp_level(input logic [31:0] d, input int j);
    logic [33:0] fr;
    fr = {2'b10, d};
    return fr[33 - j/2] ^ logic'(j % 2);
  endfunction

  // send one event; ack_delay cycles after burst end; early_ack raises sack mid-burst
  task automatic send_word(input logic [31:0] d, input int ack_delay,
                           input logic early_ack, input logic queue_next,
                           input logic [31:0] nxt);
    @(negedge clk);
    chk("R8 ready before event", in_ready, 1'b1);
    in_valid = 1'b1; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_data = ~d;   // R7: offered while busy
    for (int j = 0; j < 68; j++) begin
      chk("R3 R4 burst level", ser_out, exp_level(d, j));
      chk("R2 R6 sreq during burst", sreq, 1'b1);
      chk("R7 busy", in_ready, 1'b0);
      if (early_ack && j == 20) sack = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R5 line low after burst", ser_out, 1'b0);
    chk("R6 sreq held at end", sreq, 1'b1);
    if (!early_ack) begin
      for (int k = 0; k < ack_delay; k++) begin
        @(negedge clk);
        chk("R6 sreq waits for ack", sreq, 1'b1);
        chk("R5 quiet while waiting", ser_out, 1'b0);
      end
      sack = 1'b1;
    end
    @(negedge clk);
    chk("R6 sreq dropped", sreq, 1'b0);
    chk("R7 busy until ack drops", in_ready, 1'b0);
    @(negedge clk);
    chk("R7 still busy with sack high", in_ready, 1'b0);
    sack = 1'b0;
    if (queue_next) begin in_valid = 1'b1; in_data = nxt; end
    @(negedge clk);
    chk("R8 ready returns", in_ready, 1'b1);
    chk("R1 idle line", ser_out, 1'b0);
    chk("R1 idle sreq", sreq, 1'b0);
    if (queue_next) begin
      @(negedge clk);
      chk("R8 queued event starts", ser_out, exp_level(nxt, 0));
      chk("R8 queued sreq", sreq, 1'b1);
      in_valid = 1'b0;
      for (int j = 1; j < 68; j++) begin
        @(negedge clk);
        chk("R8 R3 queued burst", ser_out, exp_level(nxt, j));
      end
      @(negedge clk);
      sack = 1'b1;
      @(negedge clk);
      sack = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] lcg;
    #1;
    chk("R1 reset line", ser_out, 1'b0);
    chk("R1 reset sreq", sreq, 1'b0);
    chk("R1 reset ready", in_ready, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle ready", in_ready, 1'b1);
    send_word(32'h0000_0000, 0, 1'b0, 1'b0, '0);
    send_word(32'hFFFF_FFFF, 3, 1'b0, 1'b0, '0);
    send_word(32'hAAAA_5555, 1, 1'b1, 1'b0, '0);
    for (int p = 0; p < 32; p++) send_word(32'h1 << p, p % 4, 1'b0, 1'b0, '0);
    for (int p = 0; p < 32; p++) send_word(~(32'h1 << p), p % 3, p[0], 1'b0, '0);
    lcg = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send_word(lcg, i, 1'b0, i[0], ~lcg);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule